// File: doc/BRIEF.md
# NCO Phase and Frequency Control

This block generates the phase word that drives the waveform lookup of a numerically controlled oscillator. Two 32-bit frequency registers, a carrier value and a deviation value, are summed modulo 2^32 to form the per-clock phase step. The step is accumulated in a 32-bit phase register. A gate input can remove the deviation term from the sum without losing it, so frequency modulation can be switched on and off while the carrier stays put.

A 16-bit phase offset and a 2-bit quadrant shift code are added to the upper half of the accumulated phase. A range-select input then folds the result into a half circle or leaves it over the full circle. A load control zeroes the accumulator feedback, so the accumulator restarts from the current step value. All three registers load from one shared write bus, each through its own strobe. The output phase word is registered.

Top module: `nco_phase_ctrl`

## Requirements
- R1: While rst_n is low, every register is cleared, so phase_out reads 0 after reset.
- R2: The phase step is (carrier + deviation) mod 2^32, and it is added to the accumulator on every clock. Overflow wraps modulo 2^32.
- R3: A step of 0 holds the accumulator constant. A step of 0x00000001 advances it by 1 per clock. A step of 0x80000000 makes bit 31 toggle on every clock.
- R4: While dev_en_n is low, the deviation term of the sum is 0. The stored deviation value is kept, and it applies again when dev_en_n returns high.
- R5: While acc_load_n is low, the accumulator feedback is 0, so after that clock the accumulator equals the current step.
- R6: The 16-bit phase offset is added to accumulator bits 31:16 modulo 2^16. Output bits 15:0 equal accumulator bits 15:0.
- R7: quad_sel adds a quadrant shift to bits 31:16: code 00 adds 0x0000 (0°), 01 adds 0x4000 (90°), 10 adds 0xC000 (270°) and 11 adds 0x8000 (180°).
- R8: When half_range is high, output bit 31 is forced to 0 (phase modulo pi). When it is low, the full 32-bit phase is output (modulo 2pi).
- R9: A write strobe high at a rising edge loads wr_data into its register (the phase offset takes wr_data[15:0]). phase_out at edge n reflects the accumulator, offset, quad_sel and half_range as they were just before edge n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| car_we | input | 1 | Carrier frequency write strobe |
| dev_we | input | 1 | Deviation frequency write strobe |
| poff_we | input | 1 | Phase offset write strobe |
| wr_data | input | 32 | Shared write data |
| dev_en_n | input | 1 | Low gates the deviation term to zero |
| acc_load_n | input | 1 | Low zeroes the accumulator feedback |
| quad_sel | input | 2 | Quadrant shift code |
| half_range | input | 1 | High selects the modulo-pi range |
| phase_out | output | 32 | Registered phase word |

## Verification
On every cycle the assertions check that a load restarts the accumulator from the step, that a zero step holds the phase, that the deviation register keeps its value unless it is written, that the output's low half follows the accumulator, and that the half-circle mode clears the top bit. The exact sums, the wraparound of the carrier and deviation, the four quadrant codes and the restored deviation after the gate is released can only be shown by the bench. Its reference model recomputes each output word on every clock across these scenarios.

// File: rtl/nco_phase_ctrl.sv
module nco_phase_ctrl #(
  parameter int ACC_W = 32,
  parameter int OFF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             car_we,
  input  logic             dev_we,
  input  logic             poff_we,
  input  logic [ACC_W-1:0] wr_data,
  input  logic             dev_en_n,
  input  logic             acc_load_n,
  input  logic [1:0]       quad_sel,
  input  logic             half_range,
  output logic [ACC_W-1:0] phase_out
);
  localparam int LOW_W = ACC_W - OFF_W;

  logic [ACC_W-1:0] car_q, dev_q, acc_q;
  logic [OFF_W-1:0] poff_q;
  logic [ACC_W-1:0] step, fb;
  logic [OFF_W-1:0] quad_add, top;
  logic [ACC_W-1:0] phase_d;

  assign step = car_q + (dev_en_n ? dev_q : '0);
  assign fb   = acc_load_n ? acc_q : '0;

  always_comb begin
    quad_add = '0;
    case (quad_sel)
      2'b01: quad_add = OFF_W'(1) << (OFF_W - 2);
      2'b10: quad_add = OFF_W'(3) << (OFF_W - 2);
      2'b11: quad_add = OFF_W'(1) << (OFF_W - 1);
      default: quad_add = '0;
    endcase
  end

  assign top = acc_q[ACC_W-1:LOW_W] + poff_q + quad_add;

  always_comb begin
    phase_d = {top, acc_q[LOW_W-1:0]};
    if (half_range) phase_d[ACC_W-1] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      car_q     <= '0;
      dev_q     <= '0;
      poff_q    <= '0;
      acc_q     <= '0;
      phase_out <= '0;
    end else begin
      if (car_we)  car_q  <= wr_data;
      if (dev_we)  dev_q  <= wr_data;
      if (poff_we) poff_q <= wr_data[OFF_W-1:0];
      acc_q     <= fb + step;
      phase_out <= phase_d;
    end
  end

  assert_load_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_load_n |=> acc_q == $past(car_q + (dev_en_n ? dev_q : '0)));

  assert_zero_step_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_load_n && car_q == '0 && (!dev_en_n || dev_q == '0)) |=> $stable(acc_q));

  assert_dev_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_we |=> dev_q == $past(dev_q));

  assert_low_half_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> phase_out[LOW_W-1:0] == $past(acc_q[LOW_W-1:0]));

  assert_half_range_msb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    half_range |=> !phase_out[ACC_W-1]);
endmodule

// File: tb/sim_nco_phase_ctrl.sv
module sim_nco_phase_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        car_we = 0, dev_we = 0, poff_we = 0;
  logic [31:0] wr_data = 0;
  logic        dev_en_n = 1, acc_load_n = 1;
  logic [1:0]  quad_sel = 0;
  logic        half_range = 0;
  logic [31:0] phase_out;

  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R1";

  longint unsigned m_car = 0, m_dev = 0, m_poff = 0, m_acc = 0, m_out = 0;
  localparam longint unsigned M32 = 64'hFFFF_FFFF;

  always #10 clk = ~clk;

  nco_phase_ctrl u0 (.clk(clk), .rst_n(rst_n), .car_we(car_we), .dev_we(dev_we),
    .poff_we(poff_we), .wr_data(wr_data), .dev_en_n(dev_en_n), .acc_load_n(acc_load_n),
    .quad_sel(quad_sel), .half_range(half_range), .phase_out(phase_out));

  task automatic check(string req, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic longint unsigned quad_deg(logic [1:0] c);
    // 0, 90, 270, 180 degrees as fractions of 2^16
    case (c)
      2'd1: return 64'd16384;
      2'd2: return 64'd49152;
      2'd3: return 64'd32768;
      default: return 64'd0;
    endcase
  endfunction

  task automatic step();
    longint unsigned inc, o;
    @(posedge clk);
    if (!rst_n) begin
      m_car = 0; m_dev = 0; m_poff = 0; m_acc = 0; m_out = 0;
    end else begin
      inc = (m_car + (dev_en_n ? m_dev : 0)) & M32;
      o = ((m_acc % 65536) + (((m_acc / 65536) + m_poff + quad_deg(quad_sel)) % 65536) * 65536);
      if (half_range) o = o % 64'h8000_0000;
      m_out = o;
      m_acc = ((acc_load_n ? m_acc : 0) + inc) & M32;
      if (car_we) m_car = wr_data;
      if (dev_we) m_dev = wr_data;
      if (poff_we) m_poff = wr_data % 65536;
    end
    @(negedge clk);
    check(tag, phase_out, m_out);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(int which, logic [31:0] d);
    wr_data = d;
    car_we = (which == 0); dev_we = (which == 1); poff_we = (which == 2);
    step();
    car_we = 0; dev_we = 0; poff_we = 0;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    tag = "R1 reset";
    run(3);
    rst_n = 1;
    check("R1 reset output", phase_out, 0);
    run(2);

    tag = "R9 write, R3 unit step";
    wr(0, 32'h0000_0001);
    run(6);
    check("R3 unit step spot", phase_out, m_out);

    tag = "R5 load, R3 half-rate step";
    wr(0, 32'h8000_0000);
    acc_load_n = 0; step(); acc_load_n = 1;
    run(5);

    tag = "R3 zero step hold";
    wr(0, 32'h0);
    run(4);

    tag = "R2 sum with wraparound";
    wr(0, 32'h1234_5678);
    wr(1, 32'hF000_0000);
    run(6);

    tag = "R4 deviation gated";
    dev_en_n = 0;
    run(5);
    tag = "R4 deviation restored";
    dev_en_n = 1;
    run(4);

    tag = "R6 phase offset upper half";
    wr(2, 32'hFFFF_ABCD);
    run(5);

    for (int q = 0; q < 4; q++) begin
      tag = $sformatf("R7 quadrant code %0d", q);
      quad_sel = 2'(q);
      run(3);
    end
    quad_sel = 0;

    tag = "R8 modulo pi";
    half_range = 1;
    run(6);
    tag = "R8 modulo 2pi";
    half_range = 0;
    run(3);

    tag = "R5 load under offset";
    acc_load_n = 0; run(2); acc_load_n = 1;
    run(3);

    tag = "R1 reset mid-run";
    rst_n = 0; run(2); rst_n = 1;
    check("R1 reset clears output", phase_out, 0);
    run(3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule